// File: doc/BRIEF.md
# Four-Region Data Access Protection Checker

This block sits between a CPU's load/store path and the system bus. Every data access leaving the CPU is judged against four programmable address windows and a global fallback. The result is one of three answers: go ahead, try again later, or raise a data-storage exception. Each window has a base address, a size, a two-bit permission code and a guarded flag. A per-window enable lives in a single global register, which also holds the fallback permission and guarded flag.

The verdict is purely combinational from the request inputs. Configuration writes land on the next clock edge. Accesses to special registers, or into the local SRAM address window, skip the window check entirely. When the address-translation enable is low, no exception can be raised, but every speculative access headed for the system bus is held off with a retry.

Top module: `mem_prot_unit`

## Requirements
- R1: After reset every configuration register reads 0. So with translation enabled, a non-speculative access outside the bypass cases faults, because the fallback code is 00.
- R2: Register map by `cfg_addr`. Windows 0..3 take base words at 0..3, holding the base in bits [31:12]. Their attribute words sit at 4..7: size mask in [11:0], permission in [13:12], guarded flag in [16]. The global word is at 8: window enables in [3:0] (bit i enables window i), fallback permission in [13:12], fallback guarded flag in [16]. All other bits and addresses read 0 and ignore writes. A write becomes visible on `cfg_rdata` only after the next rising clock edge.
- R3: A window spans 4 KB doubled once per one-bit in its size mask (0x000 = 4 KB, 0xFFF = 16 MB). It covers the aligned block that contains its base, so base bits inside the mask are ignored.
- R4: A window whose enable bit is 0 never matches.
- R5: When several enabled windows match, the lowest-numbered one supplies the attributes.
- R6: When no enabled window matches, the fallback permission and guarded flag apply.
- R7: Permission codes: 00 denies everyone; 01 allows supervisor read/write and denies user; 10 allows supervisor read/write and user read only; 11 allows everyone. A denied access faults.
- R8: With translation on, a speculative access whose effective attributes are guarded is retried, even when it would also be denied. A non-speculative access is judged on permission alone.
- R9: With translation off, no fault is reported. A speculative access that is not bypassed is retried; every other access is permitted.
- R10: An access flagged as a special-register access, or whose address lies in the 32 KB local SRAM window at 0x0030_0000, is permitted whatever the configuration, speculation or translation state.
- R11: While `acc_valid` is high exactly one of permit, retry and fault is high. While it is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select (write and read) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| xlate_en | input | 1 | Address translation enable; when low, protection faults are off |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access byte address |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_spec | input | 1 | Access is speculative |
| acc_spr | input | 1 | Access targets special-register space |
| rsp_permit | output | 1 | Access may proceed |
| rsp_retry | output | 1 | Access must be retried |
| rsp_fault | output | 1 | Data-storage exception |

## Verification
Two window layouts are swept over every combination of access flags, all sixteen enable patterns and both translation states. The addresses are chosen on either side of each window edge, so a design with an off-by-one in the size mask would move a boundary by a page and give a wrong verdict there. Misaligned bases exercise snapping: a design that compared the masked-in base bits would lose matches inside the block. Overlapping windows expose a reversed priority. Guarded regions with denied permission show whether fault wrongly wins over retry. The SRAM window and the special-register flag are both checked with translation on and off, because a bypass applied after the guarded test would turn those accesses into retries.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned NREG     = 4;
  localparam int unsigned AW       = 32;
  localparam int unsigned DW       = 32;
  localparam int unsigned PG_LSB   = 12;
  localparam int unsigned TAG_W    = AW - PG_LSB;
  localparam int unsigned MASK_W   = 12;
  localparam int unsigned CFG_AW   = $clog2(2 * NREG + 1);
  localparam int unsigned GLB_IDX  = 2 * NREG;
  localparam int unsigned PROT_LSB = 12;
  localparam int unsigned GUARD_BIT = 16;

  localparam logic [DW-1:0] BASE_RMASK = {{TAG_W{1'b1}}, {PG_LSB{1'b0}}};
  localparam logic [DW-1:0] ATTR_RMASK = (DW'(1) << GUARD_BIT) | (DW'(3) << PROT_LSB)
                                       | ((DW'(1) << MASK_W) - DW'(1));
  localparam logic [DW-1:0] GLB_RMASK  = (DW'(1) << GUARD_BIT) | (DW'(3) << PROT_LSB)
                                       | ((DW'(1) << NREG) - DW'(1));

  typedef struct packed {
    logic       guard;
    logic [1:0] prot;
  } perm_t;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_PERMIT = 2'd1,
    RSP_RETRY  = 2'd2,
    RSP_FAULT  = 2'd3
  } rsp_e;
endpackage

// File: rtl/mpu_regfile.sv
module mpu_regfile
  import mpu_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [DW-1:0]                cfg_wdata,
  output logic [DW-1:0]                cfg_rdata,
  output logic [NREG-1:0][TAG_W-1:0]   base_o,
  output logic [NREG-1:0][MASK_W-1:0]  mask_o,
  output perm_t [NREG-1:0]             perm_o,
  output logic [NREG-1:0]              en_o,
  output perm_t                        glb_o
);
  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata;

  // shared next-state fields decoded from the write word
  logic [TAG_W-1:0]  base_d;
  logic [MASK_W-1:0] mask_d;
  perm_t             perm_d;
  logic [NREG-1:0]   en_d;

  always_comb begin
    base_d       = cfg_wdata[AW-1:PG_LSB];
    mask_d       = cfg_wdata[MASK_W-1:0];
    perm_d.prot  = cfg_wdata[PROT_LSB +: 2];
    perm_d.guard = cfg_wdata[GUARD_BIT];
    en_d         = cfg_wdata[NREG-1:0];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_win
    logic              base_we, attr_we;
    logic [TAG_W-1:0]  base_q;
    logic [MASK_W-1:0] mask_q;
    perm_t             perm_q;

    assign base_we = cfg_we && (cfg_addr == CFG_AW'(i));
    assign attr_we = cfg_we && (cfg_addr == CFG_AW'(NREG + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        perm_q <= '0;
      end else begin
        if (base_we) base_q <= base_d;
        if (attr_we) begin
          mask_q <= mask_d;
          perm_q <= perm_d;
        end
      end
    end

    assign base_o[i] = base_q;
    assign mask_o[i] = mask_q;
    assign perm_o[i] = perm_q;
  end

  logic            glb_we;
  logic [NREG-1:0] en_q;
  perm_t           glb_q;

  assign glb_we = cfg_we && (cfg_addr == CFG_AW'(GLB_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      glb_q <= '0;
    end else if (glb_we) begin
      en_q  <= en_d;
      glb_q <= perm_d;
    end
  end

  assign en_o  = en_q;
  assign glb_o = glb_q;

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (cfg_addr == CFG_AW'(i))
        cfg_rdata = {base_o[i], {PG_LSB{1'b0}}};
      if (cfg_addr == CFG_AW'(NREG + i))
        cfg_rdata = (DW'(perm_o[i].guard) << GUARD_BIT)
                  | (DW'(perm_o[i].prot) << PROT_LSB)
                  | DW'(mask_o[i]);
    end
    if (cfg_addr == CFG_AW'(GLB_IDX))
      cfg_rdata = (DW'(glb_q.guard) << GUARD_BIT)
                | (DW'(glb_q.prot) << PROT_LSB)
                | DW'(en_q);
  end
endmodule

// File: rtl/mpu_region_hit.sv
module mpu_region_hit
  import mpu_pkg::*;
(
  input  logic [TAG_W-1:0]  tag,
  input  logic [TAG_W-1:0]  base,
  input  logic [MASK_W-1:0] mask,
  input  logic              en,
  output logic              hit
);
  // bits set in the mask are "don't care"; this also snaps a misaligned base
  logic [TAG_W-1:0] care;
  assign care = ~{{(TAG_W - MASK_W){1'b0}}, mask};
  assign hit  = en && (((tag ^ base) & care) == '0);
endmodule

// File: rtl/mpu_resolve.sv
module mpu_resolve
  import mpu_pkg::*;
(
  input  logic              acc_valid,
  input  logic              xlate_en,
  input  logic              bypass,
  input  logic              acc_wr,
  input  logic              acc_super,
  input  logic              acc_spec,
  input  logic [NREG-1:0]   hit,
  input  perm_t [NREG-1:0]  perm,
  input  perm_t             glb,
  output rsp_e              rsp
);
  perm_t eff;
  logic  allowed;

  // lowest index has priority: scan downward so it is written last
  always_comb begin
    eff = glb;
    for (int i = NREG - 1; i >= 0; i--)
      if (hit[i]) eff = perm[i];
  end

  always_comb begin
    unique case (eff.prot)
      2'b00:   allowed = 1'b0;
      2'b01:   allowed = acc_super;
      2'b10:   allowed = acc_super || !acc_wr;
      default: allowed = 1'b1;
    endcase
  end

  always_comb begin
    if (!acc_valid)                rsp = RSP_NONE;
    else if (bypass)               rsp = RSP_PERMIT;
    else if (!xlate_en)            rsp = acc_spec ? RSP_RETRY : RSP_PERMIT;
    else if (eff.guard && acc_spec) rsp = RSP_RETRY;
    else if (!allowed)             rsp = RSP_FAULT;
    else                           rsp = RSP_PERMIT;
  end
endmodule

// File: rtl/mem_prot_unit.sv
module mem_prot_unit
  import mpu_pkg::*;
#(
  parameter logic [AW-1:0] SRAM_BASE = 32'h0030_0000,
  parameter int unsigned   SRAM_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              xlate_en,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_wr,
  input  logic              acc_super,
  input  logic              acc_spec,
  input  logic              acc_spr,
  output logic              rsp_permit,
  output logic              rsp_retry,
  output logic              rsp_fault
);
  logic [NREG-1:0][TAG_W-1:0]  base;
  logic [NREG-1:0][MASK_W-1:0] mask;
  perm_t [NREG-1:0]            perm;
  logic [NREG-1:0]             en;
  perm_t                       glb;
  logic [NREG-1:0]             hit;
  logic                        in_sram, bypass;
  rsp_e                        rsp;
  logic                        unused_lo;

  assign unused_lo = ^acc_addr[PG_LSB-1:0];

  mpu_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_o(base), .mask_o(mask), .perm_o(perm), .en_o(en), .glb_o(glb)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    mpu_region_hit u_hit (
      .tag(acc_addr[AW-1:PG_LSB]), .base(base[i]), .mask(mask[i]),
      .en(en[i]), .hit(hit[i])
    );
  end

  assign in_sram = (acc_addr[AW-1:SRAM_LSB] == SRAM_BASE[AW-1:SRAM_LSB]);
  assign bypass  = acc_spr || in_sram;

  mpu_resolve u_res (
    .acc_valid(acc_valid), .xlate_en(xlate_en), .bypass(bypass),
    .acc_wr(acc_wr), .acc_super(acc_super), .acc_spec(acc_spec),
    .hit(hit), .perm(perm), .glb(glb), .rsp(rsp)
  );

  assign rsp_permit = (rsp == RSP_PERMIT);
  assign rsp_retry  = (rsp == RSP_RETRY);
  assign rsp_fault  = (rsp == RSP_FAULT);
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
  import mpu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [DW-1:0]     cfg_wdata,
  input logic [DW-1:0]     cfg_rdata,
  input logic              xlate_en,
  input logic              acc_valid,
  input logic              acc_spr,
  input logic              rsp_permit,
  input logic              rsp_retry,
  input logic              rsp_fault
);
  // R11
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({rsp_permit, rsp_retry, rsp_fault}) == 1);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(rsp_permit || rsp_retry || rsp_fault));

  // R9
  xlate_off_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !xlate_en) |-> !rsp_fault);

  // R10
  spr_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_spr) |-> rsp_permit);

  // R2
  base_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < NREG) |-> (cfg_rdata[PG_LSB-1:0] == '0));

  // R2
  attr_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= NREG) |-> ((cfg_rdata & ~ATTR_RMASK) == '0));

  // R2
  base_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr < NREG) |=>
      (cfg_addr != $past(cfg_addr)) ||
      (cfg_rdata[AW-1:PG_LSB] == $past(cfg_wdata[AW-1:PG_LSB])));
endmodule

bind mem_prot_unit mpu_checker u_chk (.*);

// File: tb/tb_mem_prot_unit.sv
`timescale 1ns/1ps
module tb_mem_prot_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        xlate_en, acc_valid, acc_wr, acc_super, acc_spec, acc_spr;
  logic [31:0] acc_addr;
  logic        rsp_permit, rsp_retry, rsp_fault;

  int checks = 0;
  int errors = 0;

  // shadow configuration, filled from the register map in R2
  logic [19:0] sh_base [4];
  logic [11:0] sh_mask [4];
  logic [1:0]  sh_prot [4];
  logic        sh_grd  [4];
  logic [3:0]  sh_en;
  logic [1:0]  g_prot;
  logic        g_grd;

  always #4 clk = ~clk;

  mem_prot_unit dut (.*);

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // 0 none, 1 permit, 2 retry, 3 fault
  function automatic int model(logic [31:0] a, bit wr, bit sup, bit spec,
                               bit spr, bit xl);
    longint size, lo, aa;
    bit     found, g, ok;
    logic [1:0] pp;
    aa = longint'(a);
    if (spr || (aa >= 64'h30_0000 && aa < 64'h30_8000)) return 1;  // R10
    if (!xl) return spec ? 2 : 1;                                  // R9
    found = 0; pp = g_prot; g = g_grd;
    for (int i = 0; i < 4; i++) begin
      if (!found && sh_en[i]) begin
        size = 64'd4096 << $countones(sh_mask[i]);
        lo   = (longint'({sh_base[i], 12'h000}) / size) * size;
        if (aa >= lo && aa < lo + size) begin
          found = 1; pp = sh_prot[i]; g = sh_grd[i];
        end
      end
    end
    if (g && spec) return 2;
    case (pp)
      2'b00:   ok = 0;
      2'b01:   ok = sup;
      2'b10:   ok = sup || !wr;
      default: ok = 1;
    endcase
    return ok ? 1 : 3;
  endfunction

  function automatic int got_code();
    if ({rsp_permit, rsp_retry, rsp_fault} == 3'b000) return 0;
    if ({rsp_permit, rsp_retry, rsp_fault} == 3'b100) return 1;
    if ({rsp_permit, rsp_retry, rsp_fault} == 3'b010) return 2;
    if ({rsp_permit, rsp_retry, rsp_fault} == 3'b001) return 3;
    return 7;
  endfunction

  task automatic check_acc(string req, logic [31:0] a, bit wr, bit sup,
                           bit spec, bit spr, bit xl);
    int exp, got;
    acc_valid = 1; acc_addr = a; acc_wr = wr; acc_super = sup;
    acc_spec = spec; acc_spr = spr; xlate_en = xl;
    #1;
    exp = model(a, wr, sup, spec, spr, xl);
    got = got_code();
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d sup=%0d spec=%0d spr=%0d xl=%0d en=%b actual=%0d expected=%0d",
               req, a, wr, sup, spec, spr, xl, sh_en, got, exp);
    end
  endtask

  task automatic check_rd(string req, logic [3:0] ad, logic [31:0] exp);
    cfg_addr = ad;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s reg=%0d actual=%h expected=%h", req, ad, cfg_rdata, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] ad, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (ad < 4) sh_base[ad] = d[31:12];
    else if (ad < 8) begin
      sh_mask[ad-4] = d[11:0]; sh_prot[ad-4] = d[13:12]; sh_grd[ad-4] = d[16];
    end else if (ad == 8) begin
      sh_en = d[3:0]; g_prot = d[13:12]; g_grd = d[16];
    end
  endtask

  function automatic logic [31:0] attr(logic [11:0] m, logic [1:0] p, bit g);
    return {15'b0, g, 2'b0, p, m};
  endfunction

  function automatic logic [31:0] glbw(logic [3:0] e, logic [1:0] p, bit g);
    return {15'b0, g, 2'b0, p, 8'b0, e};
  endfunction

  function automatic logic [31:0] addr_at(int k);
    case (k)
      0:  return 32'h0000_FFFC;  1:  return 32'h0001_0000;
      2:  return 32'h0001_3FFC;  3:  return 32'h0001_4000;
      4:  return 32'h0001_7FFC;  5:  return 32'h0001_8000;
      6:  return 32'h0001_FFFC;  7:  return 32'h0002_0000;
      8:  return 32'h0010_0000;  9:  return 32'h0010_0FFC;
      10: return 32'h0010_1000;  11: return 32'h001F_FFFC;
      12: return 32'h0020_0000;  13: return 32'h0020_1FFC;
      14: return 32'h0020_2000;  15: return 32'h002F_FFFC;
      16: return 32'h0030_0000;  17: return 32'h0030_7FFC;
      18: return 32'h0030_8000;  19: return 32'h00FF_FFFC;
      20: return 32'h0100_0000;  21: return 32'hFFFF_F000;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic load_layout(int set);
    if (set == 0) begin
      wr_reg(0, 32'h0001_0000); wr_reg(4, attr(12'h003, 2'b01, 0));
      wr_reg(1, 32'h0001_3000); wr_reg(5, attr(12'h007, 2'b10, 0));
      wr_reg(2, 32'h0010_0000); wr_reg(6, attr(12'h000, 2'b11, 1));
      wr_reg(3, 32'h0020_0000); wr_reg(7, attr(12'hFFF, 2'b10, 0));
    end else begin
      wr_reg(0, 32'h0001_0000); wr_reg(4, attr(12'h000, 2'b11, 1));
      wr_reg(1, 32'h0001_8000); wr_reg(5, attr(12'h00F, 2'b00, 0));
      wr_reg(2, 32'h0010_0000); wr_reg(6, attr(12'h0FF, 2'b01, 0));
      wr_reg(3, 32'h0020_1000); wr_reg(7, attr(12'h001, 2'b11, 0));
    end
  endtask

  task automatic sweep(int set);
    string req;
    for (int e = 0; e < 16; e++) begin
      if (set == 0) wr_reg(8, glbw(4'(e), 2'b11, 0));
      else          wr_reg(8, glbw(4'(e), 2'b00, 1));
      for (int k = 0; k < 23; k++)
        for (int f = 0; f < 32; f++) begin
          if (f[3] || (addr_at(k) >= 32'h30_0000 && addr_at(k) < 32'h30_8000)) req = "R10";
          else if (!f[4]) req = "R9";
          else if (f[2]) req = "R8";
          else if (e == 0) req = "R6";
          else req = "R7";
          check_acc(req, addr_at(k), f[0], f[1], f[2], f[3], f[4]);
        end
    end
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    xlate_en = 0; acc_valid = 0; acc_addr = 0;
    acc_wr = 0; acc_super = 0; acc_spec = 0; acc_spr = 0;
    for (int i = 0; i < 4; i++) begin
      sh_base[i] = 0; sh_mask[i] = 0; sh_prot[i] = 0; sh_grd[i] = 0;
    end
    sh_en = 0; g_prot = 0; g_grd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset contents and fallback-deny behaviour
    for (int a = 0; a < 9; a++) check_rd("R1", 4'(a), 32'h0);
    check_acc("R1", 32'h0000_5000, 0, 0, 0, 0, 1);
    check_acc("R1", 32'h0000_5000, 1, 1, 0, 0, 1);

    // R11: idle request drives nothing
    acc_valid = 0; #1; checks++;
    if (got_code() != 0) begin
      errors++;
      $display("FAIL R11 idle actual=%0d expected=0", got_code());
    end

    // R2: write timing, masking of reserved bits, unmapped addresses
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = 32'hFFFF_FFFF;
    #1; checks++;
    if (cfg_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R2 early visibility actual=%h expected=%h", cfg_rdata, 32'h0);
    end
    @(negedge clk); cfg_we = 0;
    check_rd("R2", 4'd8, 32'h0001_300F);
    for (int a = 0; a < 16; a++) begin
      wr_reg(4'(a), 32'hFFFF_FFFF);
      if (a < 4)       check_rd("R2", 4'(a), 32'hFFFF_F000);
      else if (a < 8)  check_rd("R2", 4'(a), 32'h0001_3FFF);
      else if (a == 8) check_rd("R2", 4'(a), 32'h0001_300F);
      else             check_rd("R2", 4'(a), 32'h0);
    end
    for (int a = 0; a < 9; a++) wr_reg(4'(a), 32'h0);

    // directed cases on layout 0, all windows on
    load_layout(0);
    wr_reg(8, glbw(4'hF, 2'b11, 0));
    check_acc("R3", 32'h0001_3FFC, 1, 1, 0, 0, 1);  // window 0 edge, supervisor ok
    check_acc("R3", 32'h0001_4000, 0, 0, 0, 0, 1);  // past window 0, window 1 snapped
    check_acc("R5", 32'h0001_2000, 0, 0, 0, 0, 1);  // 0 beats 1: user denied
    check_acc("R8", 32'h0010_0800, 1, 0, 1, 0, 1);  // guarded speculative retried
    wr_reg(8, glbw(4'b1110, 2'b11, 0));
    check_acc("R4", 32'h0001_2000, 0, 0, 0, 0, 1);  // window 0 off: window 1 lets user read
    wr_reg(8, glbw(4'h0, 2'b01, 0));
    check_acc("R6", 32'h0001_2000, 0, 0, 0, 0, 1);  // fallback denies user
    check_acc("R10", 32'h0030_1000, 1, 0, 1, 0, 1);

    sweep(0);
    load_layout(1);
    sweep(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule